// File: doc/BRIEF.md
# Dual-Channel Multiplexed Output Formatter

This block takes two conversion streams, channel A and channel B, whose samples are captured together on one rising clock edge. It delays them through a fixed pipeline and interleaves them onto a single shared data bus. Channel A's word is launched on a rising edge. Channel B's word from the same sample follows on the next falling edge. A channel indicator shows which channel currently occupies the bus. On the way out, each word is coded either as straight offset binary or as two's complement. The incoming stream is taken to be offset binary, so two's complement is formed by inverting the most significant bit.

Two power-save controls freeze the bus: a sleep request and a full power-down request. While either is asserted, the bus and the indicator keep the last value they showed before the freeze. After release, a cycle counter keeps the bus frozen until the wake time has elapsed, and the wake time for power-down is longer than the wake time for sleep. An active-low output enable gives the bus drive indication, which stands in for tri-stating the data lines and the indicator. The output enable does not disturb the pipeline. The asynchronous reset is released synchronously inside the block.

Top module: `dual_ch_mux_fmt`

## Requirements
- R1: Both inputs are captured on the same rising edge. The channel A word of that sample is on `bus_d` from the rising edge 5 cycles after the capture edge, with `chan_a` = 1.
- R2: The channel B word of the same sample is on `bus_d` from the following falling edge (5.5 cycles after capture), with `chan_a` = 0. `chan_a` is 0 in every phase that follows a falling edge.
- R3: When `fmt_twos` = 0, the input word passes through unchanged as offset binary, with mid-scale 10'h200. When `fmt_twos` = 1, bit 9 is inverted to give two's complement, with mid-scale 10'h000. `fmt_twos` is sampled on the rising edge that loads the output words, and that edge loads both channels.
- R4: `bus_drive` equals the inverse of `oe_n` with no clock delay (1 = bus and indicator driven, 0 = high impedance). `oe_n` has no effect on the pipeline, on `bus_d` or on `chan_a`.
- R5: A rising edge that samples `pwr_dn` = 1 loads nothing. From then on, `bus_d` holds the channel B word shown just before that edge and `chan_a` stays 0.
- R6: A rising edge that samples `sleep` = 1 freezes the bus in the same way as R5.
- R7: After power-down, let r be the first rising edge that samples both `pwr_dn` and `sleep` low. The bus stays frozen through edge r+59 and resumes normal output at edge r+60.
- R8: After sleep alone, with r defined as in R7, the bus stays frozen through edge r+16 and resumes at edge r+17.
- R9: When `pwr_dn` and `sleep` are asserted together, power-down wins, and the 60-cycle wake time of R7 applies.
- R10: While reset is asserted, `bus_d` = 0 and `chan_a` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; both edges are used at the output |
| arst_n | input | 1 | Asynchronous active-low reset |
| samp_a | input | 10 | Channel A conversion word, offset binary |
| samp_b | input | 10 | Channel B conversion word, offset binary |
| fmt_twos | input | 1 | Output coding: 0 offset binary, 1 two's complement |
| oe_n | input | 1 | Active-low output enable |
| pwr_dn | input | 1 | Full power-down request |
| sleep | input | 1 | Sleep request |
| bus_d | output | 10 | Shared multiplexed data bus |
| chan_a | output | 1 | Channel indicator: 1 channel A, 0 channel B |
| bus_drive | output | 1 | Drive indication for `bus_d` and `chan_a` |

## Verification
A word driven just after rising edge k is captured at edge k+1. Its channel A result therefore reads back a quarter period after edge k+6, and its channel B result a quarter period after the falling edge that follows. The coding select is taken from the value driven one step earlier. The bench keeps a history of everything it drove and looks each expectation up at exactly that offset. In every power test, the freeze is checked from the first step after the control was sampled. The wake window is checked at every step, and the first step expected to update again is edge r+60 after power-down and edge r+17 after sleep.

// File: rtl/dcm_pkg.sv
`timescale 1ns/1ps
package dcm_pkg;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_SLEEP = 2'd1,
    PWR_DOWN  = 2'd2
  } pwr_mode_e;

  // Full power-down outranks sleep.
  function automatic pwr_mode_e decode_mode(input logic pd, input logic sl);
    if (pd) return PWR_DOWN;
    if (sl) return PWR_SLEEP;
    return PWR_RUN;
  endfunction

endpackage

// File: rtl/dcm_rst_sync.sv
`timescale 1ns/1ps
module dcm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dcm_pipe.sv
`timescale 1ns/1ps
module dcm_pipe #(
  parameter int W     = 10,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b
);

  localparam int PW = 2 * W;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      logic [PW-1:0] d;
      logic [PW-1:0] q;
      if (g == 0) begin : g_head
        assign d = {in_a, in_b};
      end else begin : g_link
        assign d = g_stage[g-1].q;
      end
      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) q <= '0;
        else         q <= d;
      end
    end
  endgenerate

  assign out_a = g_stage[DEPTH-1].q[PW-1:W];
  assign out_b = g_stage[DEPTH-1].q[W-1:0];

endmodule

// File: rtl/dcm_wake.sv
`timescale 1ns/1ps
module dcm_wake
  import dcm_pkg::*;
#(
  parameter int SLP_CYC = 17,
  parameter int DN_CYC  = 60
) (
  input  logic      clk,
  input  logic      srst_n,
  input  pwr_mode_e mode,
  output logic      upd_en
);

  localparam int MAXC = (DN_CYC > SLP_CYC) ? DN_CYC : SLP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SLP_LD = CW'(SLP_CYC);
  localparam logic [CW-1:0] DN_LD  = CW'(DN_CYC);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    unique case (mode)
      PWR_DOWN:  cnt_d = DN_LD;
      PWR_SLEEP: cnt_d = (cnt_q > SLP_LD) ? (cnt_q - ONE) : SLP_LD;
      default:   cnt_d = (cnt_q != '0) ? (cnt_q - ONE) : cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign upd_en = (mode == PWR_RUN) && (cnt_q == '0);

  // R8
  sleep_blocks_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mode != PWR_RUN) |=> !upd_en);

  // R7
  wake_cnt_range_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= DN_LD || cnt_q <= SLP_LD);

endmodule

// File: rtl/dcm_outmux.sv
`timescale 1ns/1ps
module dcm_outmux #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         upd_en,
  input  logic         fmt_twos,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] bus_d,
  output logic         chan_a
);

  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] word_a_q, word_a_d;
  logic [W-1:0] hold_b_q, hold_b_d;
  logic         tog_p_q, tog_p_d;
  logic [W-1:0] word_b_q;
  logic         tog_n_q;
  logic [W-1:0] code_mask;

  assign code_mask = fmt_twos ? MSB_MASK : '0;

  always_comb begin
    word_a_d = word_a_q;
    hold_b_d = hold_b_q;
    tog_p_d  = tog_p_q;
    if (upd_en) begin
      word_a_d = in_a ^ code_mask;
      hold_b_d = in_b ^ code_mask;
      tog_p_d  = ~tog_p_q;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      word_a_q <= '0;
      hold_b_q <= '0;
      tog_p_q  <= 1'b0;
    end else begin
      word_a_q <= word_a_d;
      hold_b_q <= hold_b_d;
      tog_p_q  <= tog_p_d;
    end
  end

  always_ff @(negedge clk or negedge srst_n) begin
    if (!srst_n) begin
      word_b_q <= '0;
      tog_n_q  <= 1'b0;
    end else begin
      word_b_q <= hold_b_q;
      tog_n_q  <= tog_p_q;
    end
  end

  assign chan_a = tog_p_q ^ tog_n_q;
  assign bus_d  = chan_a ? word_a_q : word_b_q;

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !upd_en |=> ($stable(word_a_q) && $stable(hold_b_q) && $stable(tog_p_q)));

  // R3
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!srst_n)
    upd_en |=> (word_a_q[W-2:0] == $past(in_a[W-2:0])));

  // R2
  ind_low_at_rise_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !chan_a);

endmodule

// File: rtl/dual_ch_mux_fmt.sv
`timescale 1ns/1ps
module dual_ch_mux_fmt
  import dcm_pkg::*;
#(
  parameter int DATA_W         = 10,
  parameter int LATENCY        = 5,
  parameter int WAKE_SLEEP_CYC = 17,
  parameter int WAKE_DOWN_CYC  = 60
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [DATA_W-1:0] samp_a,
  input  logic [DATA_W-1:0] samp_b,
  input  logic              fmt_twos,
  input  logic              oe_n,
  input  logic              pwr_dn,
  input  logic              sleep,
  output logic [DATA_W-1:0] bus_d,
  output logic              chan_a,
  output logic              bus_drive
);

  logic              srst_n;
  logic [DATA_W-1:0] dly_a;
  logic [DATA_W-1:0] dly_b;
  logic              upd_en;
  pwr_mode_e         mode;

  assign mode      = decode_mode(pwr_dn, sleep);
  assign bus_drive = ~oe_n;

  dcm_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  dcm_pipe #(.W(DATA_W), .DEPTH(LATENCY)) i_pipe (
    .clk    (clk),
    .srst_n (srst_n),
    .in_a   (samp_a),
    .in_b   (samp_b),
    .out_a  (dly_a),
    .out_b  (dly_b)
  );

  dcm_wake #(.SLP_CYC(WAKE_SLEEP_CYC), .DN_CYC(WAKE_DOWN_CYC)) i_wake (
    .clk    (clk),
    .srst_n (srst_n),
    .mode   (mode),
    .upd_en (upd_en)
  );

  dcm_outmux #(.W(DATA_W)) i_outmux (
    .clk      (clk),
    .srst_n   (srst_n),
    .upd_en   (upd_en),
    .fmt_twos (fmt_twos),
    .in_a     (dly_a),
    .in_b     (dly_b),
    .bus_d    (bus_d),
    .chan_a   (chan_a)
  );

endmodule

// File: tb/test_dual_ch_mux_fmt.sv
`timescale 1ns/1ps
module test_dual_ch_mux_fmt;

  localparam int CLK_PERIOD = 20;
  localparam int NV = 12;
  // {fmt_twos, samp_a, samp_b}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 10'h000, 10'h000},
    {1'b0, 10'h3FF, 10'h000},
    {1'b0, 10'h200, 10'h1FF},
    {1'b1, 10'h200, 10'h1FF},
    {1'b1, 10'h000, 10'h3FF},
    {1'b1, 10'h3FF, 10'h200},
    {1'b0, 10'h155, 10'h2AA},
    {1'b1, 10'h155, 10'h2AA},
    {1'b0, 10'h001, 10'h3FE},
    {1'b1, 10'h1FF, 10'h201},
    {1'b1, 10'h0F0, 10'h30F},
    {1'b0, 10'h2C3, 10'h13C}
  };

  logic       clk = 1'b0;
  logic       arst_n;
  logic [9:0] samp_a, samp_b;
  logic       fmt_twos, oe_n, pwr_dn, sleep;
  logic [9:0] bus_d;
  logic       chan_a, bus_drive;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_ch_mux_fmt i_dual_ch_mux_fmt (
    .clk(clk), .arst_n(arst_n), .samp_a(samp_a), .samp_b(samp_b),
    .fmt_twos(fmt_twos), .oe_n(oe_n), .pwr_dn(pwr_dn), .sleep(sleep),
    .bus_d(bus_d), .chan_a(chan_a), .bus_drive(bus_drive)
  );

  int n_chk = 0;
  int n_bad = 0;
  int t = 0;
  logic [9:0] ha [1024];
  logic [9:0] hb [1024];
  logic       hf [1024];
  logic [9:0] va = '0, vb = '0;
  logic       vf = 1'b0, v_oen = 1'b0, v_pd = 1'b0, v_sl = 1'b0;
  logic [9:0] oa, ob, frz;
  logic       oai, obi, odrv;

  function automatic logic [9:0] enc(input logic [9:0] v, input logic f);
    return v ^ {f, 9'b0};
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (step %0d)", req, act, exp, t);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    t = t + 1;
    samp_a = va; samp_b = vb; fmt_twos = vf;
    oe_n = v_oen; pwr_dn = v_pd; sleep = v_sl;
    ha[t % 1024] = va; hb[t % 1024] = vb; hf[t % 1024] = vf;
    #(CLK_PERIOD/4 - 1);
    oa = bus_d; oai = chan_a; odrv = bus_drive;
    @(negedge clk);
    #(CLK_PERIOD/4);
    ob = bus_d; obi = chan_a;
  endtask

  task automatic check_norm(input string ra, input string rb);
    logic f;
    f = hf[(t - 1) % 1024];
    check(ra, {oai, oa}, {1'b1, enc(ha[(t - 6) % 1024], f)});
    check(rb, {obi, ob}, {1'b0, enc(hb[(t - 6) % 1024], f)});
  endtask

  task automatic check_frozen(input string rq);
    check(rq, {oai, oa}, {1'b0, frz});
    check(rq, {obi, ob}, {1'b0, frz});
  endtask

  task automatic next_vals();
    va = va + 10'd37;
    vb = vb - 10'd53;
  endtask

  task automatic power_test(input string rh, input string rw, input int wake,
                            input logic pd, input logic sl);
    v_pd = pd; v_sl = sl;
    next_vals(); tick();
    check_norm("R1", "R2");
    frz = ob;
    for (int k = 0; k < 4; k++) begin
      next_vals();
      v_oen = (k == 1);
      tick();
      check_frozen(rh);
      if (k == 1) check("R4", {10'b0, odrv}, 11'd0);
      v_oen = 1'b0;
    end
    v_pd = 1'b0; v_sl = 1'b0;
    next_vals(); tick();
    check_frozen(rh);
    for (int k = 1; k <= wake + 1; k++) begin
      next_vals(); tick();
      if (k <= wake) check_frozen(rw);
      else           check_norm(rw, rw);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      ha[i] = '0; hb[i] = '0; hf[i] = 1'b0;
    end
    arst_n = 1'b0;
    samp_a = '0; samp_b = '0; fmt_twos = 1'b0; oe_n = 1'b0; pwr_dn = 1'b0; sleep = 1'b0;
    repeat (3) tick();
    // R10 reset state in both phases
    check("R10", {oai, oa}, 11'd0);
    check("R10", {obi, ob}, 11'd0);
    check("R4", {10'b0, odrv}, 11'd1);
    arst_n = 1'b1;
    repeat (8) tick();

    // Table walk: coding and both channels
    for (int i = 0; i < NV + 6; i++) begin
      if (i < NV) begin
        vf = VEC[i][20]; va = VEC[i][19:10]; vb = VEC[i][9:0];
      end
      tick();
      check_norm("R1 R3", "R2 R3");
    end

    // Running stream, coding switched every four steps
    for (int i = 0; i < 20; i++) begin
      va = 10'(i * 37 + 11);
      vb = 10'(i * 91 + 300);
      vf = i[2];
      tick();
      check_norm("R1 R3", "R2 R3");
    end
    vf = 1'b0;

    // R4 output enable: drive indication only, data path untouched
    next_vals(); v_oen = 1'b1; tick();
    check("R4", {10'b0, odrv}, 11'd0);
    check_norm("R4", "R4");
    next_vals(); tick();
    check_norm("R4", "R4");
    v_oen = 1'b0;
    next_vals(); tick();
    check("R4", {10'b0, odrv}, 11'd1);
    check_norm("R4", "R4");

    power_test("R5", "R7", 60, 1'b1, 1'b0);
    power_test("R6", "R8", 17, 1'b0, 1'b1);
    power_test("R5 R6", "R9", 60, 1'b1, 1'b1);

    for (int i = 0; i < 4; i++) begin
      next_vals(); tick();
      check_norm("R1", "R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule